// File: doc/BRIEF.md
# Burst Address Aligner and Stepper

This block supplies the byte address of every beat of a burst travelling across a packetized interconnect. The command side presents one packed word carrying a wrap-boundary mask, a two-bit burst kind, the start address and a three-bit transfer-size code. The block clears the start address's low bits so that it is a multiple of the transfer size. Each beat that the downstream side accepts then moves the address on, in the way the burst kind asks for: unchanged, a linear step, or a step that rolls over inside the wrap boundary.

A parameter picks between two builds. The sequential build holds the running address in a register and uses a valid/ready handshake with start-of-packet and end-of-packet markers. The combinational build has no state. It always returns the aligned start address together with the mask that clears the low bits. The caller forms the wrap mask: its low `size + ceil(log2(len+1))` bits are ones, and the rest are zeros.

Top module: `burst_addr_step`

## Requirements
- R1: `cmd_word` is packed as `{wrap_mask[WRAPM_W-1:0], kind[1:0], start[ADDR_W-1:0], size[2:0]}`, with the size code in bits [2:0]. A size code above log2(LANES) is treated as log2(LANES).
- R2: On the first beat of a burst, `addr_out` equals the start address with its low `size` bits cleared. `align_mask` always equals the complement of `2**size - 1`.
- R3: Kind 01 (linear): each accepted beat adds `2**size` to the address, modulo `2**ADDR_W`.
- R4: Kind 11 (reserved) behaves exactly as kind 01.
- R5: Kind 10 (wrap): after an accepted beat, the address bits where the wrap mask is one hold the low bits of the previous address plus `2**size`. The bits where the mask is zero do not change.
- R6: Kind 00 (fixed): the address stays the same on every beat of the burst.
- R7: A cycle in which `beat_valid` and `beat_ready` are not both high leaves the held address unchanged.
- R8: An accepted beat with `beat_eop` high closes the burst, and the next beat uses the new start address even without `beat_sop`. A `beat_sop` in the middle of a burst reloads the start address.
- R9: An asynchronous active-low `rst_n` clears the held address and returns the block to waiting for a first beat, so that `addr_out` shows the aligned start address.
- R10: With `INCR_EN = 0`, `addr_out` is always the aligned start address, whatever the handshake does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_word | input | WRAPM_W+ADDR_W+5 | Packed wrap mask, burst kind, start address, size code |
| beat_valid | input | 1 | A beat is offered |
| beat_ready | input | 1 | The downstream side takes the beat |
| beat_sop | input | 1 | This beat starts a burst |
| beat_eop | input | 1 | This beat ends a burst |
| addr_out | output | ADDR_W | Byte address of the current beat |
| align_mask | output | ADDR_W | Mask that clears the low address bits below the transfer size |

## Verification
The bench builds two instances with a 32-bit address, an 8-bit wrap mask and four byte lanes. One has incrementing enabled and the other is the stateless combinational build; both are driven by the same stimulus, so every burst also checks that the combinational build never moves its address. Four lanes make size code 3 legal on the input but above the lane limit, which exercises the clamp. The 32-bit width lets a linear burst that starts just below the top of the address space roll over to zero.

// File: rtl/bas_pkg.sv
package bas_pkg;

  // Burst kind codes; the stepping logic decodes these values.
  typedef enum logic [1:0] {
    BK_FIXED = 2'b00,
    BK_LINEAR = 2'b01,
    BK_WRAP = 2'b10,
    BK_RSVD = 2'b11
  } burst_kind_e;

endpackage

// File: rtl/bas_field_align.sv
module bas_field_align
  import bas_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WRAPM_W = 8,
  parameter int LANES = 4
) (
  input  logic [WRAPM_W+ADDR_W+4:0] cmd_word,
  output burst_kind_e               kind,
  output logic [ADDR_W-1:0]         start_al,
  output logic [ADDR_W-1:0]         amask,
  output logic [ADDR_W-1:0]         wmask,
  output logic [ADDR_W-1:0]         step
);
  localparam int SZ_MAX = $clog2(LANES);

  logic [2:0]        sz_raw;
  logic [2:0]        sz;
  logic [ADDR_W-1:0] start_raw;

  always_comb begin
    sz_raw    = cmd_word[2:0];
    start_raw = cmd_word[ADDR_W+2:3];
    kind      = burst_kind_e'(cmd_word[ADDR_W+4:ADDR_W+3]);
    wmask     = ADDR_W'(cmd_word[WRAPM_W+ADDR_W+4:ADDR_W+5]);
    // Limit the size code to what the lanes can carry.
    sz        = (sz_raw > 3'(SZ_MAX)) ? 3'(SZ_MAX) : sz_raw;
    step      = ADDR_W'(1) << sz;
    amask     = ~(step - ADDR_W'(1));
    start_al  = start_raw & amask;
  end
endmodule

// File: rtl/bas_next.sv
module bas_next
  import bas_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur,
  input  burst_kind_e       kind,
  input  logic [ADDR_W-1:0] step,
  input  logic [ADDR_W-1:0] wmask,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] sum;

  always_comb begin
    sum = cur + step;
    unique case (kind)
      BK_FIXED: nxt = cur;
      BK_WRAP:  nxt = (cur & ~wmask) | (sum & wmask);
      default:  nxt = sum;  // linear and reserved
    endcase
  end
endmodule

// File: rtl/bas_hold.sv
module bas_hold #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              last,
  input  logic [ADDR_W-1:0] nxt,
  output logic [ADDR_W-1:0] held,
  output logic              active
);
  logic [ADDR_W-1:0] held_d;
  logic              active_d;
  logic              en;

  always_comb begin
    en       = go;
    held_d   = nxt;
    active_d = !last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held   <= '0;
      active <= 1'b0;
    end else if (en) begin
      held   <= held_d;
      active <= active_d;
    end
  end
endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step
  import bas_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WRAPM_W = 8,
  parameter int LANES = 4,
  parameter bit INCR_EN = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [WRAPM_W+ADDR_W+4:0] cmd_word,
  input  logic                      beat_valid,
  input  logic                      beat_ready,
  input  logic                      beat_sop,
  input  logic                      beat_eop,
  output logic [ADDR_W-1:0]         addr_out,
  output logic [ADDR_W-1:0]         align_mask
);
  burst_kind_e       kind;
  logic [ADDR_W-1:0] start_al;
  logic [ADDR_W-1:0] wmask;
  logic [ADDR_W-1:0] step;

  bas_field_align #(
    .ADDR_W (ADDR_W),
    .WRAPM_W(WRAPM_W),
    .LANES  (LANES)
  ) u_fields (
    .cmd_word(cmd_word),
    .kind    (kind),
    .start_al(start_al),
    .amask   (align_mask),
    .wmask   (wmask),
    .step    (step)
  );

  generate
    if (INCR_EN) begin : g_seq
      logic [ADDR_W-1:0] held;
      logic [ADDR_W-1:0] nxt;
      logic              active;
      logic              go;

      assign go       = beat_valid && beat_ready;
      assign addr_out = (beat_sop || !active) ? start_al : held;

      bas_next #(.ADDR_W(ADDR_W)) u_next (
        .cur  (addr_out),
        .kind (kind),
        .step (step),
        .wmask(wmask),
        .nxt  (nxt)
      );

      bas_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .last  (beat_eop),
        .nxt   (nxt),
        .held  (held),
        .active(active)
      );
    end else begin : g_comb
      assign addr_out = start_al;
    end
  endgenerate
endmodule

// File: rtl/bas_check.sv
module bas_check #(
  parameter int ADDR_W = 32,
  parameter int WRAPM_W = 8,
  parameter int LANES = 4,
  parameter bit INCR_EN = 1'b1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [WRAPM_W+ADDR_W+4:0] cmd_word,
  input logic                      beat_valid,
  input logic                      beat_ready,
  input logic                      beat_sop,
  input logic                      beat_eop,
  input logic [ADDR_W-1:0]         addr_out,
  input logic [ADDR_W-1:0]         align_mask
);
  localparam int SZ_MAX = $clog2(LANES);

  logic [1:0]        kb;
  logic [2:0]        szc;
  logic [ADDR_W-1:0] stp;
  logic [ADDR_W-1:0] wm;
  logic [ADDR_W-1:0] exp_al;
  logic              acc;
  logic              mid;

  always_comb begin
    kb     = cmd_word[ADDR_W+4:ADDR_W+3];
    szc    = (cmd_word[2:0] > 3'(SZ_MAX)) ? 3'(SZ_MAX) : cmd_word[2:0];
    stp    = ADDR_W'(1) << szc;
    wm     = ADDR_W'(cmd_word[WRAPM_W+ADDR_W+4:ADDR_W+5]);
    exp_al = cmd_word[ADDR_W+2:3] & ~(stp - ADDR_W'(1));
    acc    = beat_valid && beat_ready;
  end

  // Independent view of whether a burst is under way.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mid <= 1'b0;
    else if (acc) mid <= !beat_eop;
  end

  p_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    align_mask == ~(stp - ADDR_W'(1)));

  p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!INCR_EN || !mid || beat_sop) |-> addr_out == exp_al);

  // Covers the linear kind (R3) and the reserved kind (R4).
  p_linear_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (INCR_EN && acc && !beat_eop && kb[0]) |=>
      (beat_sop || addr_out == $past(addr_out) + $past(stp)));

  p_wrap_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (INCR_EN && acc && !beat_eop && kb == 2'b10) |=>
      (beat_sop || (addr_out & ~$past(wm)) == ($past(addr_out) & ~$past(wm))));

  p_fixed_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (INCR_EN && acc && !beat_eop && kb == 2'b00) |=>
      (beat_sop || addr_out == $past(addr_out)));

  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (INCR_EN && mid && !beat_sop && !acc) |=> (beat_sop || $stable(addr_out)));

  p_eop_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (INCR_EN && acc && beat_eop) |=> addr_out == exp_al);
endmodule

bind burst_addr_step bas_check #(
  .ADDR_W (ADDR_W),
  .WRAPM_W(WRAPM_W),
  .LANES  (LANES),
  .INCR_EN(INCR_EN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_word  (cmd_word),
  .beat_valid(beat_valid),
  .beat_ready(beat_ready),
  .beat_sop  (beat_sop),
  .beat_eop  (beat_eop),
  .addr_out  (addr_out),
  .align_mask(align_mask)
);

// File: tb/sim_burst_addr_step.sv
module sim_burst_addr_step;
  localparam int AW = 32;
  localparam int MW = 8;
  localparam int NV = 7;

  typedef struct packed {
    logic [1:0]  kind;
    logic [2:0]  sz;
    logic [31:0] addr;
    logic [7:0]  mask;
    logic [7:0]  beats;
    logic [31:0] first;
    logic [31:0] last;
  } vec_t;

  // Kind codes: 00 fixed, 01 linear, 10 wrap, 11 reserved.
  localparam vec_t TBL [NV] = '{
    '{2'b01, 3'd2, 32'h1000_0003, 8'hFF, 8'd4, 32'h1000_0000, 32'h1000_000C}, // R3
    '{2'b10, 3'd2, 32'h0000_0108, 8'h0F, 8'd4, 32'h0000_0108, 32'h0000_0104}, // R5
    '{2'b00, 3'd1, 32'h0000_2345, 8'h01, 8'd3, 32'h0000_2344, 32'h0000_2344}, // R6
    '{2'b11, 3'd0, 32'h0000_00FE, 8'hFF, 8'd3, 32'h0000_00FE, 32'h0000_0100}, // R4
    '{2'b01, 3'd2, 32'hFFFF_FFF8, 8'hFF, 8'd3, 32'hFFFF_FFF8, 32'h0000_0000}, // R3 rollover
    '{2'b10, 3'd1, 32'h0000_0036, 8'h0F, 8'd8, 32'h0000_0036, 32'h0000_0034}, // R5
    '{2'b10, 3'd0, 32'h0000_0041, 8'h01, 8'd2, 32'h0000_0041, 32'h0000_0040}  // R5
  };

  logic              clk;
  logic              rst_n;
  logic [MW+AW+4:0]  word;
  logic              v, r, s, e;
  logic [AW-1:0]     a0, m0, a1, m1;
  int                checks;
  int                errors;
  bit                done;

  burst_addr_step #(.ADDR_W(AW), .WRAPM_W(MW), .LANES(4), .INCR_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_word(word), .beat_valid(v), .beat_ready(r),
    .beat_sop(s), .beat_eop(e), .addr_out(a0), .align_mask(m0)
  );

  burst_addr_step #(.ADDR_W(AW), .WRAPM_W(MW), .LANES(4), .INCR_EN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .cmd_word(word), .beat_valid(v), .beat_ready(r),
    .beat_sop(s), .beat_eop(e), .addr_out(a1), .align_mask(m1)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_word(input logic [1:0] k, input logic [2:0] sz,
                          input logic [31:0] ad, input logic [7:0] mk);
    word = {mk, k, ad, sz};
  endtask

  // Drive at the falling edge, then let the logic settle before sampling.
  task automatic beat(input logic vv, input logic rr, input logic ss, input logic ee);
    @(negedge clk);
    v = vv; r = rr; s = ss; e = ee;
    #1;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; v = 0; r = 0; s = 0; e = 0;
    set_word(2'b01, 3'd2, 32'h0000_0077, 8'hFF);
    #10;
    chk("R9 reset addr", a0, 32'h0000_0074);
    chk("R2 reset mask", m0, 32'hFFFF_FFFC);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: one burst per entry, back to back.
    for (int i = 0; i < NV; i++) begin
      set_word(TBL[i].kind, TBL[i].sz, TBL[i].addr, TBL[i].mask);
      for (int b = 0; b < int'(TBL[i].beats); b++) begin
        beat(1'b1, 1'b1, b == 0, b == int'(TBL[i].beats) - 1);
        if (b == 0) chk($sformatf("R1 R2 vec%0d first", i), a0, TBL[i].first);
        if (b == int'(TBL[i].beats) - 1) begin
          chk($sformatf("R3 R4 R5 R6 vec%0d last", i), a0, TBL[i].last);
          chk($sformatf("R10 vec%0d comb", i), a1, TBL[i].first);
        end
      end
    end
    beat(1'b0, 1'b0, 1'b0, 1'b0);

    // Stalls, reload on start, close on end.
    set_word(2'b01, 3'd2, 32'h0000_0200, 8'hFF);
    beat(1'b1, 1'b1, 1'b1, 1'b0);
    chk("R2 stall first", a0, 32'h0000_0200);
    beat(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R3 second beat", a0, 32'h0000_0204);
    beat(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R7 no valid", a0, 32'h0000_0204);
    beat(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R7 after stall", a0, 32'h0000_0204);
    chk("R10 comb stays", a1, 32'h0000_0200);
    set_word(2'b01, 3'd2, 32'h0000_0300, 8'hFF);
    beat(1'b1, 1'b1, 1'b1, 1'b0);
    chk("R8 sop reload", a0, 32'h0000_0300);
    beat(1'b1, 1'b1, 1'b0, 1'b1);
    chk("R3 before eop", a0, 32'h0000_0304);
    set_word(2'b01, 3'd2, 32'h0000_0403, 8'hFF);
    beat(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R8 idle takes start", a0, 32'h0000_0400);
    beat(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R8 idle accepted", a0, 32'h0000_0400);
    beat(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R3 held after idle start", a0, 32'h0000_0404);

    // Asynchronous reset between edges.
    #1;
    rst_n = 1'b0;
    #1;
    chk("R9 async clear", a0, 32'h0000_0400);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9 after release", a0, 32'h0000_0400);

    // Size code above the lane limit.
    set_word(2'b01, 3'd3, 32'h0000_0107, 8'hFF);
    #1;
    chk("R1 size clamp addr", a0, 32'h0000_0104);
    chk("R1 size clamp mask", m0, 32'hFFFF_FFFC);
    chk("R10 size clamp comb", a1, 32'h0000_0104);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule